// File: doc/BRIEF.md
# External Interrupt Polarity Normalizer

This block sits between a small number of external interrupt pins and a downstream interrupt controller that can only accept two kinds of request: an active-high level or a rising edge. Each pin has its own configuration word, written and read over a simple memory-mapped register bus. The word holds a line enable, a choice between level and edge sensing, and a polarity bit. The block brings each pin into the clock domain through a two-flop synchronizer. It inverts the pin when the programmed sense is active-low or falling. It then drives a registered output that is either a level copy of the corrected signal or a one-cycle pulse on its 0-to-1 transition.

Falling-edge and active-low requests are converted in hardware, so the downstream controller always sees one of two trigger kinds. A cleared enable forces the line's output low and keeps the mode bits as they are. Word offset zero is a read-only view of every line's polarity-corrected, synchronized level. It is readable whether or not the line is enabled.

Top module: `eirq_norm`

## Requirements
- R1: After reset every configuration word reads zero and every interrupt output is low.
- R2: The configuration word of line x is at byte offset 0x4 + 4*x. Bit 16 is the enable, bit 9 selects level sensing (1 = level, 0 = edge), and bit 8 is the polarity bit. A read returns these three bits as last written, and every other bit reads zero.
- R3: While the enable bit of a line is zero, that line's output is low whatever its pin does. Setting the enable again resumes normal operation, and the level and polarity bits keep their written values throughout.
- R4: With level and polarity both set (active-high level) and the line enabled, the output equals the pin. Changes appear on the second clock edge after the edge that first captures the pin.
- R5: With level set and polarity clear (active-low level) and the line enabled, the output is the inverse of the pin, with the same latency as R4.
- R6: With level and polarity both clear (rising edge) and the line enabled, a 0-to-1 pin change gives a high output for exactly one cycle, with the same latency as R4.
- R7: With level clear and polarity set (falling edge) and the line enabled, a 1-to-0 pin change gives a one-cycle high output, with the same latency as R4.
- R8: In edge sensing the output is never high in two consecutive cycles, even while the pin is held at its active value.
- R9: Byte offset 0x0 is read-only. Bit x gives the synchronized, polarity-corrected level of line x one clock edge after the pin is first captured, whatever the enable. Its other bits read zero, and writes to it change nothing.
- R10: A read of a misaligned offset or of a word beyond the last configuration word returns zero. A write to such an offset changes no configuration word.
- R11: Writing zero to a configuration word disables the line completely: the word reads zero and the output stays low.
- R12: Enabling a line in edge sensing while its pin is already held at the active value produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_LINES | Asynchronous external interrupt pins, bit x is line x |
| bus_sel | input | 1 | Register bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq_o | output | NUM_LINES | Normalized interrupt requests, active-high level or one-cycle pulse |

## Verification
Two functions can land in the same cycle: a configuration write that changes a line's enable, and a pin transition that is moving through the synchronizer toward the edge detector. The bench provokes this in two ways. It enables a line in rising-edge mode while the pin is already held high, and it clears and then sets the enable while the pin keeps toggling in level mode. It checks the output from the first cycle after each write. A pulse left over from the disabled period, or a level that outlives the mask, is judged a miscompare. Outside these directed cases, a sweep over every enable, level and polarity combination of both lines compares each output and the status word in every cycle against a delay-line model of the pins.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    // Field positions inside a line configuration word; software decodes these.
    localparam int EN_BIT  = 16;
    localparam int LVL_BIT = 9;
    localparam int POL_BIT = 8;

    typedef struct packed {
        logic en;
        logic lvl;
        logic pol;
    } line_cfg_t;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef logic [STAGES-1:0][WIDTH-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/eirq_line.sv
module eirq_line
    import eirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_sync_i,
    input  line_cfg_t cfg_i,
    output logic      corr_o,
    output logic      irq_o
);

    typedef struct packed {
        logic prev;
        logic out;
    } line_st_t;

    line_st_t st_d, st_q;
    logic     invert;
    logic     corr;

    always_comb begin
        // Active-low level and falling edge both need the pin flipped.
        invert    = cfg_i.pol ^ cfg_i.lvl;
        corr      = pin_sync_i ^ invert;
        st_d.prev = corr;
        if (!cfg_i.en) begin
            st_d.out = 1'b0;
        end else if (cfg_i.lvl) begin
            st_d.out = corr;
        end else begin
            st_d.out = corr & ~st_q.prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign corr_o = corr;
    assign irq_o  = st_q.out;

    // R3: a masked line drives nothing in the following cycle
    p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> !irq_o);

    // R8: edge sensing never yields two high cycles back to back
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !cfg_i.lvl) |=> !irq_o);

    // R4/R5: in level sensing the output is high exactly when the pin matched the polarity bit
    p_level_polarity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.en && cfg_i.lvl) |=> (irq_o == ($past(pin_sync_i) == $past(cfg_i.pol))));

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [NUM_LINES-1:0]           status_i,
    output line_cfg_t [NUM_LINES-1:0]      cfg_o
);

    localparam int WIDX_W = ADDR_W - 2;

    typedef struct packed {
        line_cfg_t [NUM_LINES-1:0] cfg;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic              aligned;
    logic [WIDX_W-1:0] word_idx;

    function automatic logic [DATA_W-1:0] cfg_word(input line_cfg_t c);
        logic [DATA_W-1:0] w;
        w          = '0;
        w[EN_BIT]  = c.en;
        w[LVL_BIT] = c.lvl;
        w[POL_BIT] = c.pol;
        return w;
    endfunction

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign word_idx = bus_addr[ADDR_W-1:2];

    always_comb begin
        regs_d    = regs_q;
        bus_rdata = '0;
        if (bus_sel && aligned) begin
            if (word_idx == '0 && !bus_wr) begin
                bus_rdata[NUM_LINES-1:0] = status_i;
            end
            for (int i = 0; i < NUM_LINES; i++) begin
                if (word_idx == WIDX_W'(i + 1)) begin
                    if (bus_wr) begin
                        regs_d.cfg[i].en  = bus_wdata[EN_BIT];
                        regs_d.cfg[i].lvl = bus_wdata[LVL_BIT];
                        regs_d.cfg[i].pol = bus_wdata[POL_BIT];
                    end else begin
                        bus_rdata = cfg_word(regs_q.cfg[i]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign cfg_o = regs_q.cfg;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_wr_chk
        // R2: a write to line g's word stores exactly the three field bits
        p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && bus_addr == ADDR_W'(4 * (g + 1)))
            |=> (cfg_o[g].en  == $past(bus_wdata[EN_BIT]) &&
                 cfg_o[g].lvl == $past(bus_wdata[LVL_BIT]) &&
                 cfg_o[g].pol == $past(bus_wdata[POL_BIT])));
    end

    // R9/R10: writes to the status word or outside the map leave every line's setup alone
    p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr &&
         (bus_addr[1:0] != 2'b00 || bus_addr[ADDR_W-1:2] == '0 ||
          bus_addr[ADDR_W-1:2] > WIDX_W'(NUM_LINES)))
        |=> $stable(regs_q));

    // R10: reads outside the map return zero
    p_unmapped_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr &&
         (bus_addr[1:0] != 2'b00 || bus_addr[ADDR_W-1:2] > WIDX_W'(NUM_LINES)))
        |-> bus_rdata == '0);

endmodule

// File: rtl/eirq_norm.sv
module eirq_norm
    import eirq_pkg::*;
#(
    parameter int NUM_LINES   = 2,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_i,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] irq_o
);

    line_cfg_t [NUM_LINES-1:0] cfg;
    logic      [NUM_LINES-1:0] pin_sync;
    logic      [NUM_LINES-1:0] corr;

    eirq_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_i),
        .dout (pin_sync)
    );

    eirq_regs #(
        .NUM_LINES(NUM_LINES),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .status_i (corr),
        .cfg_o    (cfg)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        eirq_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_sync_i(pin_sync[g]),
            .cfg_i     (cfg[g]),
            .corr_o    (corr[g]),
            .irq_o     (irq_o[g])
        );
    end

endmodule

// File: tb/eirq_norm_bench.sv
module eirq_norm_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  pin;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_o;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    // pin history: h0 = value captured at the latest edge
    logic [1:0] h0 = '0, h1 = '0, h2 = '0, h3 = '0;
    // bench model of the configuration
    logic m_en [2];
    logic m_lvl[2];
    logic m_pol[2];

    always #10 clk = ~clk;

    eirq_norm u_eirq_norm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o)
    );

    always @(posedge clk) begin
        h3 <= h2;
        h2 <= h1;
        h1 <= h0;
        h0 <= pin;
    end

    function automatic logic exp_irq(input int l);
        if (!m_en[l]) return 1'b0;
        case ({m_lvl[l], m_pol[l]})
            2'b11:   return h2[l];
            2'b10:   return !h2[l];
            2'b00:   return h2[l] && !h3[l];
            default: return !h2[l] && h3[l];
        endcase
    endfunction

    function automatic logic exp_status(input int l);
        return (m_lvl[l] == m_pol[l]) ? h1[l] : !h1[l];
    endfunction

    function automatic string mode_tag(input int l);
        if (!m_en[l]) return "R3";
        case ({m_lvl[l], m_pol[l]})
            2'b11:   return "R4";
            2'b10:   return "R5";
            2'b00:   return "R6/R8";
            default: return "R7/R8";
        endcase
    endfunction

    function automatic logic [31:0] field_word(input logic e, input logic v, input logic p);
        return (32'(e) << 16) | (32'(v) << 9) | (32'(p) << 8);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 8'h00;
        bus_wdata = '0;
    endtask

    task automatic read_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        check(bus_rdata === exp, tag, bus_rdata, exp);
        bus_addr = 8'h00;
    endtask

    task automatic set_cfg(input int l, input logic e, input logic v, input logic p, input logic [31:0] junk);
        bus_write(8'(4 + 4 * l), (junk & ~32'h0001_0300) | field_word(e, v, p));
        m_en[l]  = e;
        m_lvl[l] = v;
        m_pol[l] = p;
    endtask

    task automatic step(input logic [1:0] p, input bit chk, input string tag_ovr);
        pin = p;
        @(posedge clk);
        @(negedge clk);
        if (chk) begin
            for (int l = 0; l < 2; l++) begin
                string t;
                t = (tag_ovr == "") ? mode_tag(l) : tag_ovr;
                check(irq_o[l] === exp_irq(l), t, 32'(irq_o[l]), 32'(exp_irq(l)));
            end
            // R9: status word at offset 0 with bus parked on it
            check(bus_rdata === {30'b0, exp_status(1), exp_status(0)}, "R9", bus_rdata,
                  {30'b0, exp_status(1), exp_status(0)});
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] x;
        rst_n     = 1'b0;
        pin       = '0;
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        for (int l = 0; l < 2; l++) begin
            m_en[l] = 0; m_lvl[l] = 0; m_pol[l] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(irq_o === 2'b00, "R1", 32'(irq_o), 32'h0);
        read_check(8'h04, 32'h0, "R1");
        read_check(8'h08, 32'h0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        bus_sel = 1'b1;

        // Sweep every mode combination of both lines under pseudo-random pins
        x = 16'hACE1;
        for (int k = 0; k < 64; k++) begin
            logic [31:0] junk;
            junk = 32'(k) * 32'h9E37_79B1;
            set_cfg(0, k[2], k[1], k[0], junk);
            set_cfg(1, k[5], k[4], k[3], ~junk);
            // R2: readback holds the fields only
            read_check(8'h04, field_word(k[2], k[1], k[0]), "R2");
            read_check(8'h08, field_word(k[5], k[4], k[3]), "R2");
            for (int s = 0; s < 4; s++) step(pin, 1'b0, "");
            for (int s = 0; s < 24; s++) begin
                x = x ^ (x << 7);
                x = x ^ (x >> 9);
                x = x ^ (x << 8);
                step({x[5], x[0]}, 1'b1, "");
            end
        end

        // R8: pin held active for many cycles in rising mode gives one pulse only
        set_cfg(0, 1, 0, 0, 32'h0);
        set_cfg(1, 1, 0, 1, 32'h0);
        for (int s = 0; s < 4; s++) step(2'b10, 1'b0, "");
        for (int s = 0; s < 10; s++) step(2'b01, 1'b1, "R8");

        // R12: enable while the pin is already active, edge mode
        set_cfg(0, 0, 0, 0, 32'h0);
        for (int s = 0; s < 4; s++) step(2'b01, 1'b0, "");
        set_cfg(0, 1, 0, 0, 32'h0);
        for (int s = 0; s < 6; s++) step(2'b01, 1'b1, "R12");

        // R3: mask and unmask mid-activity, level mode; mode bits retained
        set_cfg(0, 1, 1, 1, 32'h0);
        for (int s = 0; s < 4; s++) step(2'b00, 1'b0, "");
        for (int s = 0; s < 6; s++) step(2'(s & 1), 1'b1, "R4");
        set_cfg(0, 0, 1, 1, 32'h0);
        read_check(8'h04, field_word(0, 1, 1), "R3");
        for (int s = 0; s < 6; s++) step(2'b01, 1'b1, "R3");
        set_cfg(0, 1, 1, 1, 32'h0);
        for (int s = 0; s < 6; s++) step(2'(s & 1), 1'b1, "R3");

        // R11: writing zero disables the line fully
        bus_write(8'h04, 32'h0);
        m_en[0] = 0; m_lvl[0] = 0; m_pol[0] = 0;
        read_check(8'h04, 32'h0, "R11");
        for (int s = 0; s < 8; s++) step(2'(s & 1), 1'b1, "R11");
        check(irq_o[0] === 1'b0, "R11", 32'(irq_o[0]), 32'h0);

        // R10 / R9: unmapped and status accesses
        set_cfg(0, 1, 1, 0, 32'h0);
        set_cfg(1, 0, 0, 1, 32'h0);
        read_check(8'h0C, 32'h0, "R10");
        read_check(8'h05, 32'h0, "R10");
        read_check(8'hFC, 32'h0, "R10");
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h06, 32'hFFFF_FFFF);
        bus_write(8'h09, 32'hFFFF_FFFF);
        read_check(8'h04, field_word(1, 1, 0), "R10");
        read_check(8'h08, field_word(0, 0, 1), "R10");
        bus_write(8'h00, 32'hFFFF_FFFF);
        read_check(8'h04, field_word(1, 1, 0), "R9");
        read_check(8'h08, field_word(0, 0, 1), "R9");
        for (int s = 0; s < 4; s++) step(2'b10, 1'b0, "");
        for (int s = 0; s < 4; s++) step(2'b10, 1'b1, "R9");

        done = 1;
        summary();
        $finish;
    end

endmodule